// File: doc/BRIEF.md
# Programmable I/O Window Decoder

This block turns a host I/O cycle into a chip select for one of several on-card functions. Each function owns a small set of byte-wide configuration registers: an option register holding two enable bits, up to four base-address bytes and one limit byte. The limit byte names the low address lines that the compare ignores, so each function answers to an aligned window whose size is a power of two. A select is raised only while the I/O strobe is high, the address falls inside the window, and both of the function's enable bits are set.

A limit value whose set bits do not form an unbroken run from bit 0 describes no legal window. Writing one raises a sticky per-function error flag, and that function stops decoding until a legal limit is written. When two windows overlap, the lowest-numbered function takes the cycle. A build option can drop the limit register and use a fixed mask parameter instead.

Top module: `io_win_decoder`

## Requirements
- R1: After reset every select output and every error flag is low, and all enable bits are clear.
- R2: While io_strobe_i is low, sel_o is all zero regardless of address or configuration.
- R3: A function matches when (io_addr_i & ~mask) equals (base & ~mask), where base byte k holds address bits [8k+7:8k] and mask is the limit byte zero-extended to the address width; limit 0 requires an exact address.
- R4: A function is selected only when option bit 0 (function enable) and option bit 1 (window decode enable) are both set; clearing either one stops its select.
- R5: Every address that differs from the base only in bits set in the limit byte selects the function, so both ends of the window hit and the address one past the top misses.
- R6: A configuration write to the limit byte with a value v where (v & (v+1)) != 0 sets that function's lim_err_o on the next cycle; a limit write with a contiguous low-order value clears it; the flag holds its value otherwise.
- R7: While a function's error flag is high its select output stays low.
- R8: When several functions match, only the lowest-numbered one is selected; sel_o never has more than one bit set.
- R9: Configuration register select encoding on cfg_sel_i: 0 option, 1 to 4 base bytes 0 to 3, 5 limit; base bytes at or beyond NUM_BASE (bytes 2 and 3 by default) and codes 6 and 7 are ignored and change no select.
- R10: A configuration write takes effect on the select output in the cycle after the clock edge that captures it, and affects only the function named by cfg_func_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_func_i | input | FUNC_W (1) | Function targeted by the write |
| cfg_sel_i | input | 3 | Register within the function (R9 encoding) |
| cfg_data_i | input | 8 | Write data byte |
| io_addr_i | input | ADDR_W (16) | Host I/O address |
| io_strobe_i | input | 1 | Host I/O cycle active |
| sel_o | output | NUM_FUNC (2) | Per-function chip select |
| lim_err_o | output | NUM_FUNC (2) | Sticky per-function bad-limit flag |

## Verification
The bench targets the window edges: base with the limit bits all set must hit and one past it must miss, so a design that compared the masked bits or inverted the mask would either shrink the window to one address or spill into the neighbour. It writes broken limits such as 0x05 and then a clean one, catching a flag that fails to stick, fails to clear, or leaves decoding live while set. Overlapping windows check that function 0 wins and the other select stays low, which a priority reversal or a plain OR of hits would violate. Writes to unimplemented base bytes and unused codes, and enables written one bit at a time, expose decoders that latch stray bytes or accept a single enable.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  typedef enum logic [2:0] {
    REG_OPT   = 3'd0,
    REG_BASE0 = 3'd1,
    REG_LIMIT = 3'd5
  } cfg_reg_e;

  // set bits form an unbroken run from bit 0
  function automatic logic low_run(logic [7:0] v);
    return ((v & (v + 8'd1)) == 8'd0);
  endfunction
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
  import io_win_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          NUM_BASE    = 2,
  parameter bit          HAS_LIMIT   = 1'b1,
  parameter logic [7:0]  FIXED_LIMIT = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              fn_en_o,
  output logic              win_en_o,
  output logic              err_o
);
  logic [7:0]  base_q [NUM_BASE];
  logic [31:0] base_flat;
  logic [7:0]  limit;

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[b] <= 8'h00;
      else if (we_i && sel_i == 3'(REG_BASE0 + b)) base_q[b] <= data_i;
    end
  end

  always_comb begin
    base_flat = '0;
    for (int b = 0; b < NUM_BASE; b++) base_flat[b*8 +: 8] = base_q[b];
  end
  assign base_o = base_flat[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_en_o  <= 1'b0;
      win_en_o <= 1'b0;
    end else if (we_i && sel_i == REG_OPT) begin
      fn_en_o  <= data_i[0];
      win_en_o <= data_i[1];
    end
  end

  if (HAS_LIMIT) begin : g_limit
    logic [7:0] limit_q;
    logic       err_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        limit_q <= 8'h00;
        err_q   <= 1'b0;
      end else if (we_i && sel_i == REG_LIMIT) begin
        limit_q <= data_i;
        err_q   <= !low_run(data_i);
      end
    end
    assign limit = limit_q;
    assign err_o = err_q;
  end else begin : g_fixed
    assign limit = FIXED_LIMIT;
    assign err_o = 1'b0;
  end

  assign mask_o = {{(ADDR_W-8){1'b0}}, limit};
endmodule

// File: rtl/io_win_match.sv
module io_win_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              fn_en_i,
  input  logic              win_en_i,
  input  logic              err_i,
  output logic              hit_o
);
  logic in_window;
  assign in_window = ((addr_i ^ base_i) & ~mask_i) == '0;
  assign hit_o     = strobe_i && fn_en_i && win_en_i && !err_i && in_window;
endmodule

// File: rtl/io_win_prio.sv
module io_win_prio #(
  parameter int N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + N'(1));
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import io_win_pkg::*;
#(
  parameter int         NUM_FUNC    = 2,
  parameter int         ADDR_W      = 16,
  parameter int         NUM_BASE    = 2,
  parameter bit         HAS_LIMIT   = 1'b1,
  parameter logic [7:0] FIXED_LIMIT = 8'h07,
  localparam int        FUNC_W      = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [FUNC_W-1:0]   cfg_func_i,
  input  logic [2:0]          cfg_sel_i,
  input  logic [7:0]          cfg_data_i,
  input  logic [ADDR_W-1:0]   io_addr_i,
  input  logic                io_strobe_i,
  output logic [NUM_FUNC-1:0] sel_o,
  output logic [NUM_FUNC-1:0] lim_err_o
);
  logic [NUM_FUNC-1:0] hit;

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
    logic [ADDR_W-1:0] base, mask;
    logic              fn_en, win_en, we;

    assign we = cfg_we_i && (cfg_func_i == FUNC_W'(f));

    io_win_regs #(
      .ADDR_W(ADDR_W), .NUM_BASE(NUM_BASE),
      .HAS_LIMIT(HAS_LIMIT), .FIXED_LIMIT(FIXED_LIMIT)
    ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we),
      .sel_i(cfg_sel_i), .data_i(cfg_data_i),
      .base_o(base), .mask_o(mask),
      .fn_en_o(fn_en), .win_en_o(win_en), .err_o(lim_err_o[f])
    );

    io_win_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i(io_addr_i), .strobe_i(io_strobe_i),
      .base_i(base), .mask_i(mask),
      .fn_en_i(fn_en), .win_en_i(win_en), .err_i(lim_err_o[f]),
      .hit_o(hit[f])
    );
  end

  io_win_prio #(.N(NUM_FUNC)) u_prio (.req_i(hit), .gnt_o(sel_o));
endmodule

// File: rtl/io_win_decoder_chk.sv
module io_win_decoder_chk
  import io_win_pkg::*;
#(
  parameter int NUM_FUNC  = 2,
  parameter int ADDR_W    = 16,
  parameter bit HAS_LIMIT = 1'b1,
  parameter int FUNC_W    = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [FUNC_W-1:0]   cfg_func_i,
  input logic [2:0]          cfg_sel_i,
  input logic [7:0]          cfg_data_i,
  input logic [ADDR_W-1:0]   io_addr_i,
  input logic                io_strobe_i,
  input logic [NUM_FUNC-1:0] sel_o,
  input logic [NUM_FUNC-1:0] lim_err_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (sel_o == '0 || io_strobe_i) ; // R1
    if (!rst_ni) AST_RESET_NO_ERR: assert (lim_err_o == '0); // R1
  end

  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_strobe_i |-> sel_o == '0); // R2

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R8

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(lim_err_o)); // R6

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_f
    AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lim_err_o[f] |-> !sel_o[f]); // R7

    if (HAS_LIMIT) begin : g_lim
      AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_func_i == FUNC_W'(f) && cfg_sel_i == REG_LIMIT
         && !low_run(cfg_data_i)) |=> lim_err_o[f]); // R6

      AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_func_i == FUNC_W'(f) && cfg_sel_i == REG_LIMIT
         && low_run(cfg_data_i)) |=> !lim_err_o[f]); // R6
    end
  end
endmodule

bind io_win_decoder io_win_decoder_chk #(
  .NUM_FUNC(NUM_FUNC), .ADDR_W(ADDR_W), .HAS_LIMIT(HAS_LIMIT), .FUNC_W(FUNC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_func_i(cfg_func_i),
  .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i), .io_addr_i(io_addr_i),
  .io_strobe_i(io_strobe_i), .sel_o(sel_o), .lim_err_o(lim_err_o)
);

// File: tb/io_win_decoder_test.sv
module io_win_decoder_test;
  localparam int NF = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_func_i = '0;
  logic [2:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_data_i = '0;
  logic [15:0] io_addr_i = '0;
  logic        io_strobe_i = 1'b0;
  logic [NF-1:0] sel_o, lim_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [7:0] m_base [NF][2];
  logic [7:0] m_lim [NF];
  bit m_fen [NF], m_wen [NF], m_err [NF];

  always #2 clk_i = ~clk_i;

  io_win_decoder uut (.*);

  function automatic logic [NF-1:0] exp_sel(logic [15:0] a, bit stb);
    logic [NF-1:0] r = '0;
    for (int f = 0; f < NF; f++) begin
      logic [15:0] b = {m_base[f][1], m_base[f][0]};
      logic [15:0] k = {8'h00, m_lim[f]};
      if (stb && m_fen[f] && m_wen[f] && !m_err[f] && ((a & ~k) == (b & ~k))) begin
        r[f] = 1'b1;
        break;
      end
    end
    return r;
  endfunction

  function automatic logic [NF-1:0] exp_err();
    logic [NF-1:0] r;
    for (int f = 0; f < NF; f++) r[f] = m_err[f];
    return r;
  endfunction

  task automatic wr(int f, int s, logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_func_i = 1'(f); cfg_sel_i = 3'(s); cfg_data_i = d;
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    case (s)
      0: begin m_fen[f] = d[0]; m_wen[f] = d[1]; end
      1: m_base[f][0] = d;
      2: m_base[f][1] = d;
      5: begin m_lim[f] = d; m_err[f] = ((d & (d + 8'd1)) != 8'd0); end
      default: ;
    endcase
  endtask

  task automatic probe(string req, logic [15:0] a, bit stb);
    logic [NF-1:0] es, ee;
    @(negedge clk_i);
    io_addr_i = a; io_strobe_i = stb;
    #1;
    es = exp_sel(a, stb); ee = exp_err();
    checks++;
    if (sel_o !== es || lim_err_o !== ee) begin
      fails++;
      $display("FAIL %s addr=%h sel=%b/%b err=%b/%b (actual/expected)",
               req, a, sel_o, es, lim_err_o, ee);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog sel=%b expected completion", sel_o);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int f = 0; f < NF; f++) begin
      m_base[f][0] = 0; m_base[f][1] = 0; m_lim[f] = 0;
      m_fen[f] = 0; m_wen[f] = 0; m_err[f] = 0;
    end
    #1;
    io_strobe_i = 1'b1;
    #1;
    checks++;
    if (sel_o !== '0 || lim_err_o !== '0) begin
      fails++;
      $display("FAIL R1 reset sel=%b err=%b expected 00/00", sel_o, lim_err_o);
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    probe("R1", 16'h0000, 1'b1);

    // R4: base set, enables one at a time
    wr(0, 1, 8'h40); wr(0, 2, 8'h03);
    probe("R4", 16'h0340, 1'b1);
    wr(0, 0, 8'h01); probe("R4", 16'h0340, 1'b1);
    wr(0, 0, 8'h02); probe("R4", 16'h0340, 1'b1);
    wr(0, 0, 8'h03); probe("R4 R10", 16'h0340, 1'b1);
    // R3: exact match with limit 0
    probe("R3", 16'h0341, 1'b1);
    probe("R3", 16'h1340, 1'b1);
    // R2
    probe("R2", 16'h0340, 1'b0);
    // R5: window 0x340..0x34F
    wr(0, 5, 8'h0F);
    probe("R5", 16'h0340, 1'b1);
    probe("R5", 16'h034F, 1'b1);
    probe("R5", 16'h0350, 1'b1);
    probe("R5", 16'h033F, 1'b1);
    // R6/R7
    wr(0, 5, 8'h05);
    probe("R6 R7", 16'h0340, 1'b1);
    wr(0, 1, 8'h40);
    probe("R6", 16'h0340, 1'b1);
    wr(0, 5, 8'h07);
    probe("R6", 16'h0345, 1'b1);
    // R8: overlapping windows
    wr(1, 1, 8'h40); wr(1, 2, 8'h03); wr(1, 5, 8'h1F); wr(1, 0, 8'h03);
    probe("R8", 16'h0342, 1'b1);
    probe("R8", 16'h0358, 1'b1);
    // R9: ignored base bytes and codes; R10 other function untouched
    wr(0, 3, 8'hFF); wr(0, 4, 8'hAA); wr(0, 6, 8'h00); wr(1, 7, 8'hFF);
    probe("R9", 16'h0342, 1'b1);
    probe("R9 R10", 16'h0358, 1'b1);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        int f = $urandom_range(0, NF - 1);
        int s = $urandom_range(0, 7);
        logic [7:0] d = 8'($urandom);
        if (s == 5 && $urandom_range(0, 3) != 0) d = 8'hFF >> $urandom_range(0, 8);
        if (s == 0 && $urandom_range(0, 3) != 0) d = 8'h03;
        wr(f, s, d);
      end else begin
        int f = $urandom_range(0, NF - 1);
        logic [15:0] a = {m_base[f][1], m_base[f][0]} ^ (16'($urandom) & {8'h00, m_lim[f]});
        if ($urandom_range(0, 4) == 0) a = 16'($urandom);
        probe("R3 R5 R8 random", a, $urandom_range(0, 7) != 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule